// File: doc/BRIEF.md
# Target Read Data Burst Sourcer

This block sits on the application side of a bus target core. It supplies the data for a target read. The core signals the end of the address phase by pulsing an active-low acknowledge. While that acknowledge is low, the block latches three values:

- whether the access is a burst;
- how many words the burst carries;
- whether the transfer path is 32 or 16 bits wide.

Once the acknowledge is released, the block pulls words from an application stream that uses valid/ready handshaking. It writes them into the core's read-data FIFO with an active-low write strobe. It stops whenever the FIFO reports that it is full.

On the 16-bit path, every 32-bit word goes out as two beats, the low half first and then the high half. The source word is consumed only on the high-half beat. If the FIFO fills between the two halves, the pending half waits on the output. An active-low last flag marks the final beat of the phase. After that beat the block returns to idle and waits for the next acknowledge.

Back-pressure rules for the source stream:
- `src_ready` is high only in a cycle in which a word completes its last beat into the FIFO.
- The source must hold `src_valid` and `src_data` unchanged until it sees `src_ready`.
- The source may withdraw `src_valid` only at a word boundary.

Top module: `tdr_burst_src`

## Requirements
- R1: A command is latched in an idle cycle where `tack_n` is 0. No write strobe is issued while `tack_n` is 0. The first strobe can occur no earlier than the cycle after the first clock edge at which `tack_n` is sampled at 1.
- R2: `rd_wen_n` is 0 only in a cycle where `fifo_full_n` is 1 (a 1 on `fifo_full_n` means the FIFO has space).
- R3: Each cycle with `rd_wen_n` at 0 moves one item. On the 32-bit path, `rd_data` equals `src_data`, and `src_ready` is 1 in that same cycle.
- R4: `rd_last_n` is 0 only in a cycle where `rd_wen_n` is also 0.
- R5: A burst command supplies `cmd_len_m1`+1 words. `rd_last_n` stays 1 on every beat except the final one.
- R6: In the cycle after `rd_last_n` is 0, `rd_wen_n` is 1, and the block is idle and ready for a new command.
- R7: On the 16-bit path, each word takes two beats. `rd_data[15:0]` carries bits 15:0 first and then bits 31:16, and `rd_data[31:16]` reads 0. `src_ready` is 1 only on the second beat. `rd_last_n` is 0 only on the second beat of the final word.
- R8: A full FIFO between the two halves of a word pauses the transfer. The pending half is sent afterwards, and no half is lost or repeated.
- R9: A non-burst command transfers exactly one word, whatever the value of `cmd_len_m1`.
- R10: When `rst_n` is 0 at a clock edge, the block returns to idle: `rd_wen_n`=1, `rd_last_n`=1, `src_ready`=0.
- R11: The path width (`cmd_half`, where 1 selects 16 bits) is sampled at command capture. Later changes to it have no effect until the next command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tack_n | input | 1 | Address-phase acknowledge from the core, active low |
| cmd_burst | input | 1 | Access is a burst (1) or a single word (0) |
| cmd_len_m1 | input | LEN_W | Burst word count minus one |
| cmd_half | input | 1 | 1 selects the 16-bit path |
| src_valid | input | 1 | Source word is valid |
| src_ready | output | 1 | Source word is consumed this cycle |
| src_data | input | DATA_W | Source read word |
| fifo_full_n | input | 1 | Read-data FIFO has space when 1 |
| rd_wen_n | output | 1 | FIFO write strobe, active low |
| rd_last_n | output | 1 | Final beat of the read phase, active low |
| rd_data | output | DATA_W | Data written to the FIFO |

## Verification
The assertions assume four things about the inputs:
- the core drives `tack_n` low only while the block is idle, and never during a running phase;
- the source follows the valid/ready hold rule, so a word stays put while its halves are in flight;
- `src_valid` drops only at word boundaries;
- `DATA_W` is even.

The stimulus keeps within these limits:
- it pulses the acknowledge for one cycle before each phase and keeps it high otherwise;
- it advances the source word only after a handshake;
- it inserts source gaps only when no half word is pending;
- it drives `fifo_full_n` with periodic full patterns, one of which forces pauses between halves.

// File: rtl/tdr_pkg.sv
package tdr_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ARM  = 2'd1,
    PH_RUN  = 2'd2
  } phase_e;
endpackage

// File: rtl/tdr_phase_fsm.sv
module tdr_phase_fsm
  import tdr_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tack_n,
  input  logic             cmd_burst,
  input  logic [LEN_W-1:0] cmd_len_m1,
  input  logic             cmd_half,
  input  logic             word_done,
  output logic             running,
  output logic             final_word,
  output logic             half_mode
);
  phase_e           phase_q, phase_d;
  logic [LEN_W-1:0] left_q;
  logic             half_q;
  logic             capture;

  assign capture = (phase_q == PH_IDLE) && !tack_n;

  always_comb begin
    phase_d = phase_q;
    case (phase_q)
      PH_IDLE: if (!tack_n) phase_d = PH_ARM;
      PH_ARM:  if (tack_n) phase_d = PH_RUN;
      PH_RUN:  if (word_done && final_word) phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      left_q  <= '0;
      half_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      if (capture) begin
        left_q <= cmd_burst ? cmd_len_m1 : '0;
        half_q <= cmd_half;
      end else if (running && word_done && !final_word) begin
        left_q <= left_q - LEN_W'(1);
      end
    end
  end

  assign running    = (phase_q == PH_RUN);
  assign final_word = (left_q == '0);
  assign half_mode  = half_q;

  // R1: an armed phase does not start while the acknowledge is still held
  p_arm_waits_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_ARM && !tack_n) |=> (phase_q != PH_RUN));

  // R6: completing the final word ends the phase
  p_final_word_exits_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (running && word_done && final_word) |=> (phase_q == PH_IDLE));

  // R11: path width is frozen outside idle
  p_mode_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_IDLE) |=> $stable(half_mode));
endmodule

// File: rtl/tdr_lane_split.sv
module tdr_lane_split #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              half_mode,
  input  logic              beat,
  input  logic [DATA_W-1:0] src_data,
  output logic [DATA_W-1:0] lane_data,
  output logic              upper,
  output logic              lane_final
);
  localparam int HALF_W = DATA_W / 2;

  logic upper_q;

  always_ff @(posedge clk) begin
    if (!rst_n) upper_q <= 1'b0;
    else if (beat && half_mode) upper_q <= ~upper_q;
  end

  always_comb begin
    if (!half_mode) lane_data = src_data;
    else if (upper_q) lane_data = {{HALF_W{1'b0}}, src_data[DATA_W-1:HALF_W]};
    else lane_data = {{HALF_W{1'b0}}, src_data[HALF_W-1:0]};
  end

  assign upper      = upper_q;
  assign lane_final = !half_mode || upper_q;

  // R7: a lower-half beat is always followed by the upper half
  p_upper_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && half_mode && !upper_q) |=> upper_q);

  // R7: after the upper half the next word starts low
  p_wraps_to_lower_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && upper_q) |=> !upper_q);

  // R8: a pending upper half survives a stall
  p_pending_half_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (upper_q && !beat) |=> upper_q);
endmodule

// File: rtl/tdr_strobe_gen.sv
module tdr_strobe_gen (
  input  logic running,
  input  logic src_valid,
  input  logic fifo_full_n,
  input  logic final_word,
  input  logic lane_final,
  output logic beat,
  output logic word_done,
  output logic wen_n,
  output logic last_n
);
  assign beat      = running && src_valid && fifo_full_n;
  assign word_done = beat && lane_final;
  assign wen_n     = !beat;
  assign last_n    = !(word_done && final_word);
endmodule

// File: rtl/tdr_burst_src.sv
module tdr_burst_src #(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tack_n,
  input  logic              cmd_burst,
  input  logic [LEN_W-1:0]  cmd_len_m1,
  input  logic              cmd_half,
  input  logic              src_valid,
  output logic              src_ready,
  input  logic [DATA_W-1:0] src_data,
  input  logic              fifo_full_n,
  output logic              rd_wen_n,
  output logic              rd_last_n,
  output logic [DATA_W-1:0] rd_data
);
  logic running, final_word, half_mode;
  logic beat, word_done, upper, lane_final;

  tdr_phase_fsm #(.LEN_W(LEN_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .tack_n     (tack_n),
    .cmd_burst  (cmd_burst),
    .cmd_len_m1 (cmd_len_m1),
    .cmd_half   (cmd_half),
    .word_done  (word_done),
    .running    (running),
    .final_word (final_word),
    .half_mode  (half_mode)
  );

  tdr_lane_split #(.DATA_W(DATA_W)) u_lane (
    .clk        (clk),
    .rst_n      (rst_n),
    .half_mode  (half_mode),
    .beat       (beat),
    .src_data   (src_data),
    .lane_data  (rd_data),
    .upper      (upper),
    .lane_final (lane_final)
  );

  tdr_strobe_gen u_strobe (
    .running     (running),
    .src_valid   (src_valid),
    .fifo_full_n (fifo_full_n),
    .final_word  (final_word),
    .lane_final  (lane_final),
    .beat        (beat),
    .word_done   (word_done),
    .wen_n       (rd_wen_n),
    .last_n      (rd_last_n)
  );

  assign src_ready = word_done;

  // R2: never write into a full FIFO
  p_wen_needs_space_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_wen_n |-> fifo_full_n);

  // R4: last flag only accompanies a write
  p_last_with_wen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_last_n |-> !rd_wen_n);

  // R6: strobe drops right after the last beat
  p_wen_off_after_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_last_n |=> rd_wen_n);

  // R1: no write while the acknowledge is held
  p_no_wen_in_ack_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !tack_n |-> rd_wen_n);

  // R3: a word is consumed only on a write cycle
  p_ready_on_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    src_ready |-> (!rd_wen_n && src_valid));

  // R7: in 16-bit mode the word is taken on its upper half only
  p_ready_upper_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (src_ready && half_mode) |-> upper);
endmodule

// File: tb/sim_tdr_burst_src.sv
module sim_tdr_burst_src;
  localparam int DW = 32;
  localparam int LW = 8;
  localparam int NV = 8;

  // {half, burst, gap, pad, stall[3:0], len_m1[7:0], base[31:0]}
  localparam logic [47:0] VEC [NV] = '{
    {1'b0, 1'b1, 1'b0, 1'b0, 4'd0, 8'd3,  32'h1000_0000},
    {1'b0, 1'b1, 1'b1, 1'b0, 4'd3, 8'd7,  32'hA5A5_0000},
    {1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 8'd5,  32'hDEAD_BEEF},
    {1'b1, 1'b1, 1'b0, 1'b0, 4'd0, 8'd2,  32'h1234_5678},
    {1'b1, 1'b1, 1'b0, 1'b0, 4'd2, 8'd4,  32'hCAFE_0001},
    {1'b1, 1'b0, 1'b0, 1'b0, 4'd0, 8'd9,  32'h8765_4321},
    {1'b1, 1'b1, 1'b1, 1'b0, 4'd3, 8'd0,  32'h0F0F_F0F0},
    {1'b0, 1'b1, 1'b1, 1'b0, 4'd5, 8'd15, 32'h5555_AAAA}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tack_n = 1'b1;
  logic          cmd_burst = 1'b0;
  logic [LW-1:0] cmd_len_m1 = '0;
  logic          cmd_half = 1'b0;
  logic          src_valid = 1'b0;
  logic          src_ready;
  logic [DW-1:0] src_data = '0;
  logic          fifo_full_n = 1'b1;
  logic          rd_wen_n, rd_last_n;
  logic [DW-1:0] rd_data;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  tdr_burst_src #(.DATA_W(DW), .LEN_W(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .tack_n(tack_n), .cmd_burst(cmd_burst),
    .cmd_len_m1(cmd_len_m1), .cmd_half(cmd_half), .src_valid(src_valid),
    .src_ready(src_ready), .src_data(src_data), .fifo_full_n(fifo_full_n),
    .rd_wen_n(rd_wen_n), .rd_last_n(rd_last_n), .rd_data(rd_data)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_txn(input bit half, input bit burst, input bit gap, input int stall,
                         input logic [7:0] len, input logic [31:0] base, input bit flip);
    int beats = 0, taken = 0, errs = 0, full_viol = 0, last_at = -1, exp_beats;
    bit done = 0;
    logic [31:0] w, ev;
    exp_beats = (burst ? int'(len) + 1 : 1) * (half ? 2 : 1);
    // capture cycle: acknowledge held, source and FIFO ready (R1)
    @(negedge clk);
    tack_n = 1'b0; cmd_burst = burst; cmd_len_m1 = len; cmd_half = half;
    src_valid = 1'b1; src_data = base; fifo_full_n = 1'b1;
    #1 chk(rd_wen_n === 1'b1, "R1 no strobe during ack", 32'(rd_wen_n), 32'd1);
    // armed cycle: acknowledge released, still no strobe (R1)
    @(negedge clk);
    tack_n = 1'b1;
    if (flip) cmd_half = ~half;
    #1 chk(rd_wen_n === 1'b1, "R1 no strobe in release cycle", 32'(rd_wen_n), 32'd1);
    for (int cyc = 0; cyc < 400 && !done; cyc++) begin
      @(negedge clk);
      fifo_full_n = !(stall != 0 && (cyc % stall) == 1);
      src_valid = !(gap && (cyc % 4) == 3 && !(half && beats[0]));
      src_data = base + 32'(taken);
      #1;
      if (!rd_wen_n) begin
        if (!fifo_full_n) full_viol++;
        w = base + 32'(half ? beats / 2 : beats);
        ev = !half ? w : (beats[0] ? {16'h0, w[31:16]} : {16'h0, w[15:0]});
        if (rd_data !== ev) errs++;
        if (!rd_last_n) begin
          last_at = beats;
          done = 1;
        end
        beats++;
      end
      if (src_valid && src_ready) taken++;
    end
    @(negedge clk);
    src_valid = 1'b0;
    #1 chk(rd_wen_n === 1'b1 && rd_last_n === 1'b1, "R6 strobe off after last",
           {30'd0, rd_wen_n, rd_last_n}, 32'd3);
    chk(beats == exp_beats, half ? "R7 R5 R9 beat count" : "R5 R9 beat count",
        32'(beats), 32'(exp_beats));
    chk(errs == 0, half ? "R7 R8 half order and data" : "R3 data per beat", 32'(errs), 32'd0);
    chk(last_at == exp_beats - 1, "R4 R5 R7 last flag position", 32'(last_at), 32'(exp_beats - 1));
    chk(full_viol == 0, "R2 strobe while full", 32'(full_viol), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(rd_wen_n === 1'b1, "R10 reset strobe", 32'(rd_wen_n), 32'd1);
    chk(rd_last_n === 1'b1, "R10 reset last", 32'(rd_last_n), 32'd1);
    chk(src_ready === 1'b0, "R10 reset ready", 32'(src_ready), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      run_txn(VEC[i][47], VEC[i][46], VEC[i][45], int'(VEC[i][43:40]),
              VEC[i][39:32], VEC[i][31:0], 1'b0);
    end

    // R11: width flips after capture, 16-bit behaviour must persist
    run_txn(1'b1, 1'b1, 1'b0, 0, 8'd2, 32'h3C3C_9696, 1'b1);
    // R11: the reverse direction
    run_txn(1'b0, 1'b1, 1'b0, 0, 8'd1, 32'h7777_0001, 1'b1);

    // R10: reset in the middle of a long burst
    @(negedge clk);
    tack_n = 1'b0; cmd_burst = 1'b1; cmd_len_m1 = 8'd20; cmd_half = 1'b0;
    src_valid = 1'b1; fifo_full_n = 1'b1; src_data = 32'h0;
    @(negedge clk);
    tack_n = 1'b1;
    repeat (4) @(negedge clk);
    #1 chk(rd_wen_n === 1'b0, "R10 burst running before reset", 32'(rd_wen_n), 32'd0);
    rst_n = 1'b0;
    @(negedge clk);
    #1;
    chk(rd_wen_n === 1'b1, "R10 strobe after mid reset", 32'(rd_wen_n), 32'd1);
    chk(rd_last_n === 1'b1, "R10 last after mid reset", 32'(rd_last_n), 32'd1);
    chk(src_ready === 1'b0, "R10 ready after mid reset", 32'(src_ready), 32'd0);
    rst_n = 1'b1;
    src_valid = 1'b0;
    run_txn(1'b1, 1'b1, 1'b0, 2, 8'd1, 32'hBEEF_0042, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule